// File: doc/BRIEF.md
# Multi-Mode Pulse Width and Pulse Density Generator

This block drives two digital outputs from a pair of 16-bit value registers and a 3-bit mode field. All three registers are loaded over a simple write-only register bus. A one-cycle enable, `tick_en`, stands for the PWM clock, so an external prescaler sets the rate. Every counter and accumulator advances only on cycles where `tick_en` is high.

In variable-period mode, value A sets the pulse length and value B sets the cycle length. The effective resolution therefore follows the period setting. The duty and period are copied into shadow registers at each cycle boundary, so a bus write can never produce a partial pulse. In dual density mode, each channel owns a 16-bit accumulator that adds its value on every tick and emits the carry. The carry gives a non-return-to-zero bit stream whose high count over 65536 ticks equals the programmed value. Such a stream can be low-pass filtered into an analog level.

A per-channel output enable tells the surrounding pin logic whether that channel currently owns the pin. In the other mode encodings both outputs are held low and both pins are released.

Top module: `pwm_sd_gen`

## Requirements
- R1: After reset, `out0`, `out1`, `oe0` and `oe1` are low, and the mode field is 0.
- R2: The register bus decodes `wr_addr` as follows: 0 writes the mode from `wr_data[2:0]`, 1 writes value A, 2 writes value B, and 3 is ignored. Only mode code 1 (variable PWM) and mode code 4 (dual density) are active; every other code holds both outputs low.
- R3: In mode 1, with D = value A and P = value B, each output cycle lasts P ticks, or 1 tick when P = 0. `out0` is high for the first min(D,P) ticks of each cycle, starting with the first tick after entering the mode. `out1` stays low.
- R4: In mode 1, a D of 0 gives a constant low `out0`, and a D that is at least P gives a constant high `out0`.
- R5: In mode 1, a new D or P written during a cycle takes effect only from the next cycle boundary.
- R6: In mode 4, over any 65536 consecutive ticks, `out0` is high on exactly value-A ticks.
- R7: In mode 4, `out1` follows the R6 rule independently, using value B.
- R8: In mode 4, a value write is applied from the very next tick. The accumulator starts at 0 on entry into the mode.
- R9: On cycles with `tick_en` low, the outputs and all counting state hold their values.
- R10: `oe0` is high in modes 1 and 4. `oe1` is high only in mode 4. Each enable follows the mode register by one clock.
- R11: After the mode register leaves an active mode, both outputs are low from the next clock on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | PWM clock enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 value A, 2 value B |
| wr_data | input | 16 | Write data |
| out0 | output | 1 | Channel 0 pulse output |
| out1 | output | 1 | Channel 1 pulse output |
| oe0 | output | 1 | Channel 0 pin ownership |
| oe1 | output | 1 | Channel 1 pin ownership |

## Verification
Mode 1 is tried with a table of duty and period pairs: an ordinary fraction, a zero duty, a duty equal to the period, a duty above the period, a period of 1 and a period of 0. The high count is taken over two successive cycles, which separates a wrong cycle length from a wrong compare. A duty write in the middle of a cycle shows whether the shadow copy is taken at the boundary or at once. Mode 4 runs one full 65536-tick window with two unrelated values to prove exact density per channel. Short windows at one half and one quarter show that a new value is taken immediately. Unused mode codes and idle ticks confirm that nothing moves when it should not.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;
  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_VAR  = 3'd1,
    MODE_RSV2 = 3'd2,
    MODE_RSV3 = 3'd3,
    MODE_DSD  = 3'd4,
    MODE_RSV5 = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } pwm_mode_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_VALA = 2'd1;
  localparam logic [1:0] ADDR_VALB = 2'd2;
endpackage

// File: rtl/pwm_sd_regs.sv
module pwm_sd_regs
  import pwm_sd_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [VW-1:0] wr_data,
  output pwm_mode_e     mode_o,
  output logic [VW-1:0] val_a_o,
  output logic [VW-1:0] val_b_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o  <= MODE_OFF;
      val_a_o <= '0;
      val_b_o <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_MODE: mode_o  <= pwm_mode_e'(wr_data[2:0]);
        ADDR_VALA: val_a_o <= wr_data;
        ADDR_VALB: val_b_o <= wr_data;
        default: ;
      endcase
    end
  end

  // R2: a write to the spare address leaves every register untouched
  a_r2_spare_addr: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == 2'd3 |=> $stable(mode_o) && $stable(val_a_o) && $stable(val_b_o));
endmodule

// File: rtl/pwm_var_core.sv
module pwm_var_core #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          tick,
  input  logic [VW-1:0] duty_in,
  input  logic [VW-1:0] per_in,
  output logic          pwm_o
);
  localparam int CW = VW + 1;

  logic [VW-1:0] cnt, duty_sh, per_sh;
  logic          wrap;

  assign wrap = ({1'b0, cnt} + CW'(1)) >= {1'b0, per_sh};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      duty_sh <= '0;
      per_sh  <= '0;
      pwm_o   <= 1'b0;
    end else if (!active) begin
      cnt     <= '0;
      duty_sh <= duty_in;
      per_sh  <= per_in;
      pwm_o   <= 1'b0;
    end else if (tick) begin
      pwm_o <= cnt < duty_sh;
      if (wrap) begin
        cnt     <= '0;
        duty_sh <= duty_in;
        per_sh  <= per_in;
      end else begin
        cnt <= cnt + VW'(1);
      end
    end
  end

  // R3: the counter stays inside the programmed cycle
  a_r3_cnt_in_cycle: assert property (@(posedge clk) disable iff (rst)
    active && per_sh != '0 |-> cnt < per_sh);
  // R4: a zero duty never produces a high tick
  a_r4_zero_duty: assert property (@(posedge clk) disable iff (rst)
    active && tick && duty_sh == '0 |=> !pwm_o);
  // R5: the shadow duty only moves at a cycle boundary
  a_r5_shadow_at_wrap: assert property (@(posedge clk) disable iff (rst)
    active && !$stable(duty_sh) |-> cnt == '0);
  // R9: no tick, no movement
  a_r9_var_hold: assert property (@(posedge clk) disable iff (rst)
    active && !tick |=> $stable(cnt) && $stable(pwm_o));
endmodule

// File: rtl/pwm_sd_chan.sv
module pwm_sd_chan #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          tick,
  input  logic [VW-1:0] val_in,
  output logic          dens_o
);
  localparam int SW = VW + 1;

  logic [VW-1:0] acc;
  logic [SW-1:0] sum;

  assign sum = {1'b0, acc} + {1'b0, val_in};

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      acc    <= '0;
      dens_o <= 1'b0;
    end else if (tick) begin
      acc    <= sum[VW-1:0];
      dens_o <= sum[VW];
    end
  end

  // R6: a zero value never emits a carry
  a_r6_zero_value: assert property (@(posedge clk) disable iff (rst)
    active && tick && val_in == '0 |=> !dens_o);
  // R8: the full-scale value emits a carry whenever the accumulator is nonzero
  a_r8_full_scale: assert property (@(posedge clk) disable iff (rst)
    active && tick && val_in == '1 && acc != '0 |=> dens_o);
  // R9: the accumulator holds without a tick
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (rst)
    active && !tick |=> $stable(acc) && $stable(dens_o));
endmodule

// File: rtl/pwm_sd_gen.sv
module pwm_sd_gen
  import pwm_sd_pkg::*;
#(
  parameter int VW = 16,
  parameter int NCH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [VW-1:0] wr_data,
  output logic          out0,
  output logic          out1,
  output logic          oe0,
  output logic          oe1
);
  pwm_mode_e     mode_q;
  logic [VW-1:0] val_a, val_b;
  logic          var_on, dsd_on, var_pwm;
  logic [NCH-1:0]         dens;
  logic [NCH-1:0][VW-1:0] vals;

  pwm_sd_regs #(.VW(VW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_o(mode_q), .val_a_o(val_a), .val_b_o(val_b)
  );

  assign var_on = (mode_q == MODE_VAR);
  assign dsd_on = (mode_q == MODE_DSD);
  assign vals   = {val_b, val_a};

  pwm_var_core #(.VW(VW)) var_i (
    .clk(clk), .rst(rst), .active(var_on), .tick(tick_en),
    .duty_in(val_a), .per_in(val_b), .pwm_o(var_pwm)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_sd_chan #(.VW(VW)) chan_i (
      .clk(clk), .rst(rst), .active(dsd_on), .tick(tick_en),
      .val_in(vals[g]), .dens_o(dens[g])
    );
  end

  // each source is a flop that is forced low outside its own mode
  assign out0 = var_pwm | dens[0];
  assign out1 = dens[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      oe0 <= 1'b0;
      oe1 <= 1'b0;
    end else begin
      oe0 <= var_on | dsd_on;
      oe1 <= dsd_on;
    end
  end

  // R2 / R11: inactive modes drive nothing from the next clock on
  a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
    !var_on && !dsd_on |=> !out0 && !out1);
  // R3: channel 1 is quiet in the single PWM mode
  a_r3_out1_quiet: assert property (@(posedge clk) disable iff (rst)
    var_on |=> !out1);
  // R10: enables track the mode register one clock later
  a_r10_oe_track: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> oe0 == ($past(mode_q) == MODE_VAR || $past(mode_q) == MODE_DSD)
             && oe1 == ($past(mode_q) == MODE_DSD));
  // R1: reset clears the pins
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> !out0 && !out1 && !oe0 && !oe1);
endmodule

// File: tb/pwm_sd_gen_tb.sv
`timescale 1ns/1ps
module pwm_sd_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out0, out1, oe0, oe1;

  int total = 0;
  int bad = 0;
  int c0, c1;
  logic first0;

  always #2.5 clk = ~clk;

  pwm_sd_gen dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out0(out0), .out1(out1), .oe0(oe0), .oe1(oe1)
  );

  // {duty, period, expected highs per cycle}
  localparam logic [47:0] VEC [8] = '{
    {16'd3,  16'd8,  16'd3},
    {16'd0,  16'd8,  16'd0},
    {16'd8,  16'd8,  16'd8},
    {16'd20, 16'd8,  16'd8},
    {16'd5,  16'd1,  16'd1},
    {16'd1,  16'd0,  16'd1},
    {16'd0,  16'd0,  16'd0},
    {16'd7,  16'd16, 16'd7}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    c0 = 0; c1 = 0;
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 0) first0 = out0;
      c0 += int'(out0);
      c1 += int'(out1);
    end
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] d, p, e, plen;
    logic h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 out0", int'(out0), 0);
    chk("R1 out1", int'(out1), 0);
    chk("R1 oe", int'({oe0, oe1}), 0);

    // R3 / R4 table walk
    for (int v = 0; v < 8; v++) begin
      d = VEC[v][47:32]; p = VEC[v][31:16]; e = VEC[v][15:0];
      plen = (p == 0) ? 16'd1 : p;
      wr(2'd0, 16'd0);
      idle(2);
      wr(2'd1, d);
      wr(2'd2, p);
      wr(2'd0, 16'd1);
      ticks(int'(plen));
      chk($sformatf("R3 R4 vec%0d cycle1", v), c0, int'(e));
      chk($sformatf("R3 vec%0d first tick", v), int'(first0), int'(e != 0));
      ticks(int'(plen));
      chk($sformatf("R3 R4 vec%0d cycle2", v), c0, int'(e));
      chk($sformatf("R3 vec%0d out1", v), c1, 0);
    end
    // R10 in mode 1
    chk("R10 mode1 oe", int'({oe0, oe1}), 2);

    // R5 and R9: mid-cycle duty write
    wr(2'd0, 16'd0);
    idle(2);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd8);
    wr(2'd0, 16'd1);
    ticks(3);
    chk("R5 partial old duty", c0, 2);
    h0 = out0;
    wr(2'd1, 16'd6);
    idle(10);
    chk("R9 hold out0", int'(out0), int'(h0));
    ticks(5);
    chk("R5 rest of cycle old duty", c0, 0);
    ticks(8);
    chk("R5 next cycle new duty", c0, 6);

    // R2: unused mode codes and spare address
    wr(2'd1, 16'd4);
    wr(2'd0, 16'd2);
    idle(2);
    ticks(20);
    chk("R2 mode2 out0", c0, 0);
    chk("R2 mode2 oe", int'({oe0, oe1}), 0);
    wr(2'd0, 16'd7);
    ticks(20);
    chk("R2 mode7 outputs", c0 + c1, 0);
    wr(2'd0, 16'd1);
    wr(2'd3, 16'd0);
    ticks(8);
    chk("R2 spare address ignored", c0, 4);

    // R8: immediate value pick-up in mode 4
    wr(2'd0, 16'd0);
    idle(2);
    wr(2'd1, 16'h8000);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd4);
    ticks(16);
    chk("R8 half density", c0, 8);
    chk("R7 zero density", c1, 0);
    chk("R10 mode4 oe", int'({oe0, oe1}), 3);
    wr(2'd1, 16'h4000);
    ticks(16);
    chk("R8 quarter density", c0, 4);

    // R6 / R7: full window
    wr(2'd0, 16'd0);
    idle(2);
    wr(2'd1, 16'd12345);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'd4);
    ticks(65536);
    chk("R6 window out0", c0, 12345);
    chk("R7 window out1", c1, 65535);

    // R11: leave the mode while out1 is high
    ticks(3);
    chk("R11 out1 high before exit", int'(out1), 1);
    wr(2'd0, 16'd0);
    idle(1);
    chk("R11 outputs low", int'({out0, out1}), 0);
    chk("R10 oe low after exit", int'({oe0, oe1}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule